// File: doc/BRIEF.md
# Lockable Per-CPU Reset Vector Table

A small register bank that gives every CPU of a cluster its own boot address. Each CPU owns one 64-bit slot. Software writes the physical address at which that CPU begins fetching after a reset or a wake from sleep. The table drives that address to the CPU, aligned to a 4 KiB page. Boot firmware normally loads a slot and seals it in the same write: a written value whose bit 0 is set stores the address and locks the slot. A locked slot ignores every later write until the system reset clears it.

Each CPU has a reset-release input. When release rises, the slot's current page-aligned address is copied to that CPU's vector output. The output then holds that value while the CPU runs, even if software changes the slot later. Register reads take one cycle.

Top module: `rvt_table`

## Requirements
- R1: After reset every slot holds zero and is unlocked. Every vector output is zero, and the read data output is zero.
- R2: A write to byte offset 8*i, for i below N_CPU, changes only slot i. A read of that slot returns the written bits [PA_W-1:12]. Bits [63:PA_W] and bits [11:1] read as zero.
- R3: A write with bit 0 set stores the address and locks the slot in the same cycle. A read of a locked slot returns bit 0 as 1; an unlocked slot returns bit 0 as 0.
- R4: Writes to a locked slot change neither its address nor its lock bit.
- R5: The lock of one slot has no effect on writes to any other slot.
- R6: On the rising edge of release i, vector output i takes slot i's address with bits [11:0] forced to zero. It stays unchanged while release i remains high.
- R7: A write to an offset that is not a multiple of 8, or whose index is N_CPU or above, changes no slot. A read of such an offset returns zero.
- R8: System reset clears every lock, so a slot that was locked accepts writes again after reset.
- R9: Read data appears on the clock edge that follows the cycle in which the read request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| reg_valid_i | input | 1 | Register access request |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | ADDR_W | Byte offset of the access |
| reg_wdata_i | input | 64 | Write data; bit 0 requests lock |
| reg_rdata_o | output | 64 | Read data, valid one cycle after a read |
| cpu_release_i | input | N_CPU | Per-CPU reset release |
| cpu_vec_o | output | N_CPU x 64 | Per-CPU page-aligned start address |

## Verification
The bench tries to rewrite a locked slot, with the lock bit both set and clear. A table that let such a write through would leave the slot's address open to change after boot. It locks one slot and then writes its neighbours, which exposes a lock that reaches the wrong slot. It also probes misaligned offsets and offsets just past the last CPU, where a careless decoder would alias onto slot 0 or return stale data. Slots are rewritten while release is held high, which catches a vector that tracks the register instead of holding its captured value. Finally a reset in mid-run must clear the locks.

// File: rtl/rvt_pkg.sv
package rvt_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned PAGE_W = 12;

  function automatic logic [DATA_W-1:0] page_mask(input int unsigned pa_w);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < DATA_W; b++) m[b] = (b >= PAGE_W) && (b < pa_w);
    return m;
  endfunction
endpackage

// File: rtl/rvt_decode.sv
module rvt_decode #(
  parameter int unsigned N_CPU  = 4,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned IDX_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [ADDR_W-1:0] slot;
  assign slot  = {3'b000, addr_i[ADDR_W-1:3]};
  assign hit_o = (addr_i[2:0] == 3'b000) && (slot < ADDR_W'(N_CPU));
  assign idx_o = slot[IDX_W-1:0];
endmodule

// File: rtl/rvt_entry.sv
module rvt_entry
  import rvt_pkg::*;
#(
  parameter int unsigned PA_W = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              release_i,
  output logic [DATA_W-1:0] fld_o,
  output logic              lock_o,
  output logic [DATA_W-1:0] vec_o
);
  localparam logic [DATA_W-1:0] KEEP = page_mask(PA_W);

  logic [DATA_W-1:0] fld_q, vec_q;
  logic              lock_q, rel_q;
  logic              unused_bits;

  assign unused_bits = ^(wdata_i & ~KEEP & ~DATA_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fld_q  <= '0;
      lock_q <= 1'b0;
    end else if (wr_i && !lock_q) begin
      fld_q  <= wdata_i & KEEP;
      lock_q <= wdata_i[0];
    end
  end

  // capture on rising release only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_q <= 1'b0;
      vec_q <= '0;
    end else begin
      rel_q <= release_i;
      if (release_i && !rel_q) vec_q <= fld_q;
    end
  end

  assign fld_o  = fld_q;
  assign lock_o = lock_q;
  assign vec_o  = vec_q;
endmodule

// File: rtl/rvt_table.sv
module rvt_table
  import rvt_pkg::*;
#(
  parameter int unsigned N_CPU  = 4,
  parameter int unsigned PA_W   = 40,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          reg_valid_i,
  input  logic                          reg_write_i,
  input  logic [ADDR_W-1:0]             reg_addr_i,
  input  logic [63:0]                   reg_wdata_i,
  output logic [63:0]                   reg_rdata_o,
  input  logic [N_CPU-1:0]              cpu_release_i,
  output logic [N_CPU-1:0][63:0]        cpu_vec_o
);
  localparam int unsigned IDX_W = (N_CPU > 1) ? $clog2(N_CPU) : 1;

  logic                    hit;
  logic [IDX_W-1:0]        idx;
  logic [N_CPU-1:0][63:0]  fld_w;
  logic [N_CPU-1:0]        lock_w;
  logic [63:0]             rdata_q;

  rvt_decode #(.N_CPU(N_CPU), .ADDR_W(ADDR_W)) i_dec (
    .addr_i (reg_addr_i),
    .hit_o  (hit),
    .idx_o  (idx)
  );

  for (genvar g = 0; g < N_CPU; g++) begin : g_slot
    logic wr_sel;
    assign wr_sel = reg_valid_i && reg_write_i && hit && (idx == IDX_W'(g));
    rvt_entry #(.PA_W(PA_W)) i_entry (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_sel),
      .wdata_i   (reg_wdata_i),
      .release_i (cpu_release_i[g]),
      .fld_o     (fld_w[g]),
      .lock_o    (lock_w[g]),
      .vec_o     (cpu_vec_o[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (reg_valid_i && !reg_write_i)
      rdata_q <= hit ? (fld_w[idx] | {63'b0, lock_w[idx]}) : '0;
  end

  assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/rvt_checker.sv
module rvt_checker #(
  parameter int unsigned N_CPU  = 4,
  parameter int unsigned ADDR_W = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   reg_valid_i,
  input logic                   reg_write_i,
  input logic [ADDR_W-1:0]      reg_addr_i,
  input logic [63:0]            reg_rdata_o,
  input logic [N_CPU-1:0]       cpu_release_i,
  input logic [N_CPU-1:0][63:0] cpu_vec_o,
  input logic [N_CPU-1:0][63:0] fld_i,
  input logic [N_CPU-1:0]       lock_i
);
  logic mapped;
  assign mapped = (reg_addr_i[2:0] == 3'b000) &&
                  ({3'b000, reg_addr_i[ADDR_W-1:3]} < ADDR_W'(N_CPU));

  p_unmapped_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_valid_i && !reg_write_i && !mapped |=> reg_rdata_o == 64'd0);

  for (genvar g = 0; g < N_CPU; g++) begin : g_chk
    p_lock_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_i[g] |=> lock_i[g]);
    p_locked_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_i[g] |=> $stable(fld_i[g]));
    p_vec_aligned_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_vec_o[g][11:0] == 12'd0);
    p_vec_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_release_i[g] && $past(cpu_release_i[g]) |=> $stable(cpu_vec_o[g]));
    p_read_lockbit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reg_valid_i && !reg_write_i &&
      reg_addr_i == ADDR_W'(8 * g) && lock_i[g] |=> reg_rdata_o[0]);
  end
endmodule

bind rvt_table rvt_checker #(.N_CPU(N_CPU), .ADDR_W(ADDR_W)) i_rvt_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_valid_i   (reg_valid_i),
  .reg_write_i   (reg_write_i),
  .reg_addr_i    (reg_addr_i),
  .reg_rdata_o   (reg_rdata_o),
  .cpu_release_i (cpu_release_i),
  .cpu_vec_o     (cpu_vec_o),
  .fld_i         (fld_w),
  .lock_i        (lock_w)
);

// File: tb/test_rvt_table.sv
`timescale 1ns/1ps
module test_rvt_table;
  localparam int N = 4;
  localparam int PA_W = 40;
  localparam int AW = 8;
  localparam logic [63:0] KEEP = ((64'd1 << PA_W) - 1) & ~64'hfff;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              valid = 1'b0, write = 1'b0;
  logic [AW-1:0]     addr = '0;
  logic [63:0]       wdata = '0;
  logic [63:0]       rdata;
  logic [N-1:0]      rel = '0;
  logic [N-1:0][63:0] vec;

  logic [63:0] m_fld [N];
  logic        m_lock[N];
  logic [63:0] m_vec [N];
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rvt_table #(.N_CPU(N), .PA_W(PA_W), .ADDR_W(AW)) i_rvt_table (
    .clk_i(clk), .rst_ni(rst_n), .reg_valid_i(valid), .reg_write_i(write),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .cpu_release_i(rel), .cpu_vec_o(vec));

  function automatic logic [63:0] exp_read(input logic [AW-1:0] a);
    int i;
    if (a[2:0] != 0 || int'(a >> 3) >= N) return 64'd0;
    i = int'(a >> 3);
    return m_fld[i] | {63'd0, m_lock[i]};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_fld[i] = '0; m_lock[i] = 0; m_vec[i] = '0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; rel = '0; valid = 0;
    model_reset();
    @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [63:0] d);
    int i;
    @(negedge clk); valid = 1; write = 1; addr = a; wdata = d;
    @(negedge clk); valid = 0; write = 0;
    if (a[2:0] == 0 && int'(a >> 3) < N) begin
      i = int'(a >> 3);
      if (!m_lock[i]) begin m_fld[i] = d & KEEP; m_lock[i] = d[0]; end
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req);
    @(negedge clk); valid = 1; write = 0; addr = a;
    @(negedge clk); valid = 0;
    check(req, rdata, exp_read(a)); // R9: valid after one edge
  endtask

  task automatic set_rel(input int i, input logic v, input string req);
    @(negedge clk); rel[i] = v;
    if (v && !m_rel_bit(i)) m_vec[i] = m_fld[i];
    @(negedge clk);
    check(req, vec[i], m_vec[i]);
  endtask

  function automatic logic m_rel_bit(input int i);
    return rel_prev[i];
  endfunction
  logic [N-1:0] rel_prev = '0;
  always @(posedge clk) rel_prev <= rel;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", rdata, 64'd0);
    for (int i = 0; i < N; i++) check("R1 vec", vec[i], 64'd0);
    for (int i = 0; i < N; i++) rd(AW'(8*i), "R1 slot");

    // R2 plain store, page aligned, high bits dropped
    wr(8'h00, 64'h0000_0012_3456_7abc); rd(8'h00, "R2 store");
    wr(8'h18, 64'hffff_ffff_ffff_fffe); rd(8'h18, "R2 width");
    rd(8'h08, "R2 other slot untouched");
    // R3 store and lock at once
    wr(8'h08, 64'h0000_00ab_cde0_1001); rd(8'h08, "R3 lock");
    check("R3 value", rdata, 64'h0000_00ab_cde0_1001);
    // R4 locked ignores
    wr(8'h08, 64'h0000_0000_0555_0000); rd(8'h08, "R4 clear-lock write");
    wr(8'h08, 64'h0000_0000_0777_7001); rd(8'h08, "R4 lock write");
    // R5 independence
    wr(8'h10, 64'h0000_0000_4444_4000); rd(8'h10, "R5 neighbour");
    wr(8'h00, 64'h0000_0000_1111_1000); rd(8'h00, "R5 slot0");
    // R7 unmapped
    wr(8'h20, 64'h0000_0000_9999_9001); wr(8'h04, 64'h0000_0000_8888_8000);
    wr(8'h09, 64'h0000_0000_8888_8001);
    rd(8'h20, "R7 past end"); rd(8'h04, "R7 misaligned");
    for (int i = 0; i < N; i++) rd(AW'(8*i), "R7 no alias");
    // R6 capture and hold
    set_rel(1, 1'b1, "R6 capture");
    check("R6 aligned", vec[1], 64'h0000_00ab_cde0_1000);
    set_rel(0, 1'b1, "R6 capture0");
    wr(8'h00, 64'h0000_0000_2222_2000);
    @(negedge clk); check("R6 hold", vec[0], 64'h0000_0000_1111_1000);
    set_rel(0, 1'b0, "R6 drop");
    set_rel(0, 1'b1, "R6 recapture");
    // R8 reset clears lock
    do_reset();
    rd(8'h08, "R8 cleared");
    wr(8'h08, 64'h0000_0000_3333_3000); rd(8'h08, "R8 writable");
    check("R8 vec", vec[1], 64'd0);

    // random mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [AW-1:0] a;
      logic [63:0] d;
      op = int'($urandom % 4);
      a  = AW'(8 * ($urandom % N));
      d  = {$urandom, $urandom};
      d[0] = (($urandom % 8) == 0);
      case (op)
        0: wr(a, d);
        1: rd(a, "R2 random read");
        2: begin
             a = AW'($urandom % 64);
             if ($urandom % 2) wr(a, d); else rd(a, "R7 random offset");
           end
        default: begin
             int c;
             c = int'($urandom % N);
             set_rel(c, ~rel[c], "R6 random release");
           end
      endcase
      if (n == 300) do_reset();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule